// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash and decides when an embedded program or erase has finished. A one-cycle start pulse arms it with a status address and a poll budget. It then issues status reads through a simple bus-master port: the request is held until a one-cycle valid returns the data byte. Bit 6 of the status byte flips on every read while the flash is busy. Bit 5 rises when the flash has gone over its internal time limit.

The poller reads status in pairs and keeps the bit-6 value from the first read of each pair. It compares that value with bit 6 of the second read. A stable bit means the operation has finished. If the bit is still flipping and bit 5 is high, the poller takes one more pair of reads before it declares a failure, because the flipping may have stopped on the same read that raised bit 5. Every failure ends with a write of the reset command F0h to the status address. This returns the flash to array reads. The outcome is reported as a one-cycle done pulse with a pass/fail flag.

Top module: `tbp_poll_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o and wr_req_o are all 0.
- R2: A start_i pulse while idle captures poll_addr_i and max_polls_i and raises busy_o on the next edge. All later bus accesses of that operation use the captured address. A request stays high until bus_valid_i, and each cycle with bus_valid_i high completes exactly one access.
- R3: If bit 6 (mask 40h) of the second read of a pair equals bit 6 of the first read, the operation ends with pass=1. Two reads are used and nothing is written.
- R4: If bit 6 differs and bit 5 (mask 20h) of the second read is 0, polling restarts with a new pair. The first read of the new pair becomes the new reference.
- R5: If bit 6 differs and bit 5 of the second read is 1, exactly two confirmation reads follow. Equal bit 6 values on these reads give pass=1.
- R6: If bit 6 still differs on the confirmation pair, a write request (wr_req_o) is issued with data F0h at the captured address. Read and write requests are never high together. Once the write completes, the operation ends with pass=0.
- R7: After max_polls_i pairs that each show a bit-6 change with bit 5 low, the poller takes the reset-write path and ends with pass=0. A budget of 0 is treated as 1.
- R8: done_o is high for exactly one cycle, and pass_o is valid in that cycle. busy_o falls on the same edge that raises done_o. A start_i present in the done cycle is accepted.
- R9: A start_i while busy_o is high has no effect: no change to the address, the budget, the sequence or the result.
- R10: On a second read with bit 6 unchanged and bit 5 high, the result is pass=1 with no confirmation reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch pulse, accepted only while idle |
| poll_addr_i | input | ADDR_W | Status/reset-command address, captured at start |
| max_polls_i | input | CNT_W | Budget of toggling pairs with bit 5 low (0 acts as 1) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Result, valid with done_o |
| rd_req_o | output | 1 | Status read request, held until bus_valid_i |
| wr_req_o | output | 1 | Reset-command write request, held until bus_valid_i |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | 8 | Write data (F0h during the reset write) |
| bus_rdata_i | input | 8 | Read data, valid with bus_valid_i |
| bus_valid_i | input | 1 | Access complete |

## Verification
The decision that matters most is what happens when the timeout flag and the end of toggling show up in the same status byte. The bench supplies a second read whose bit 6 matches the reference while bit 5 is high. It expects a pass on that same read, with no confirmation pair and no reset write. A second case lands the completion pulse and a new start in the same cycle. There the bench expects the second operation to be accepted at once, and it judges both cases against a cycle-by-cycle behavioural model.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  localparam int DATA_W      = 8;
  localparam int TOG_BIT     = 6;
  localparam int TMO_BIT     = 5;
  localparam logic [DATA_W-1:0] RESET_CMD = 8'hF0;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REF   = 3'd1,
    ST_CMP   = 3'd2,
    ST_VREF  = 3'd3,
    ST_VCMP  = 3'd4,
    ST_ABORT = 3'd5
  } tbp_state_e;
endpackage

// File: rtl/tbp_bit_track.sv
module tbp_bit_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic sample_i,
  output logic differs_o
);
  logic ref_q;
  logic ref_d;

  always_comb begin
    ref_d = ref_q;
    if (load_i) ref_d = sample_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_d;
  end

  assign differs_o = sample_i ^ ref_q;
endmodule

// File: rtl/tbp_poll_limit.sv
module tbp_poll_limit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             step_i,
  output logic             last_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [EXT_W-1:0] cnt_next;

  assign cnt_next = {1'b0, cnt_q} + EXT_W'(1);
  assign last_o   = cnt_next >= {1'b0, lim_q};

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (arm_i) begin
      cnt_d = '0;
      lim_d = (limit_i == '0) ? CNT_W'(1) : limit_i;
    end else if (step_i) begin
      cnt_d = cnt_next[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> ({1'b0, cnt_q} < {1'b0, lim_q})); // R7
endmodule

// File: rtl/tbp_seq_fsm.sv
module tbp_seq_fsm
  import tbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rsp_valid_i,
  input  logic       rsp_differs_i,
  input  logic       rsp_timeout_i,
  input  logic       last_pair_i,
  output tbp_state_e state_o,
  output logic       arm_o,
  output logic       load_ref_o,
  output logic       step_o,
  output logic       done_o,
  output logic       pass_o
);
  tbp_state_e st_q, st_d;
  logic       done_q, pass_q, pass_d;
  logic       fin, fin_pass;

  always_comb begin
    st_d       = st_q;
    arm_o      = 1'b0;
    load_ref_o = 1'b0;
    step_o     = 1'b0;
    fin        = 1'b0;
    fin_pass   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          arm_o = 1'b1;
          st_d  = ST_REF;
        end
      end
      ST_REF: begin
        if (rsp_valid_i) begin
          load_ref_o = 1'b1;
          st_d       = ST_CMP;
        end
      end
      ST_CMP: begin
        if (rsp_valid_i) begin
          if (!rsp_differs_i) begin
            fin      = 1'b1;
            fin_pass = 1'b1;
          end else if (rsp_timeout_i) begin
            st_d = ST_VREF;
          end else begin
            step_o = 1'b1;
            st_d   = last_pair_i ? ST_ABORT : ST_REF;
          end
        end
      end
      ST_VREF: begin
        if (rsp_valid_i) begin
          load_ref_o = 1'b1;
          st_d       = ST_VCMP;
        end
      end
      ST_VCMP: begin
        if (rsp_valid_i) begin
          if (!rsp_differs_i) begin
            fin      = 1'b1;
            fin_pass = 1'b1;
          end else begin
            st_d = ST_ABORT;
          end
        end
      end
      ST_ABORT: begin
        if (rsp_valid_i) fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
    if (fin) st_d = ST_IDLE;
  end

  always_comb begin
    pass_d = pass_q;
    if (fin) pass_d = fin_pass;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      pass_q <= pass_d;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;
  assign pass_o  = pass_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE)); // R8
endmodule

// File: rtl/tbp_poll_ctrl.sv
module tbp_poll_ctrl
  import tbp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              rd_req_o,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_valid_i
);
  tbp_state_e        state;
  logic              arm, load_ref, step, last_pair, differs;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rsp_unused;

  assign rsp_unused = ^{bus_rdata_i[DATA_W-1:TOG_BIT+1], bus_rdata_i[TMO_BIT-1:0]};

  always_comb begin
    addr_d = addr_q;
    if (arm) addr_d = poll_addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  tbp_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .rsp_valid_i   (bus_valid_i),
    .rsp_differs_i (differs),
    .rsp_timeout_i (bus_rdata_i[TMO_BIT]),
    .last_pair_i   (last_pair),
    .state_o       (state),
    .arm_o         (arm),
    .load_ref_o    (load_ref),
    .step_o        (step),
    .done_o        (done_o),
    .pass_o        (pass_o)
  );

  tbp_bit_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_ref),
    .sample_i  (bus_rdata_i[TOG_BIT]),
    .differs_o (differs)
  );

  tbp_poll_limit #(.CNT_W(CNT_W)) u_limit (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm),
    .limit_i (max_polls_i),
    .step_i  (step),
    .last_o  (last_pair)
  );

  assign busy_o      = (state != ST_IDLE);
  assign rd_req_o    = (state == ST_REF) || (state == ST_CMP) ||
                       (state == ST_VREF) || (state == ST_VCMP);
  assign wr_req_o    = (state == ST_ABORT);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wr_req_o ? RESET_CMD : '0;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_o && wr_req_o)); // R6
  AST_ABORT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (bus_wdata_o == RESET_CMD)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rd_req_o || wr_req_o)); // R1
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o)); // R2
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !bus_valid_i) |=> rd_req_o); // R2
endmodule

// File: tb/tbp_poll_ctrl_test.sv
module tbp_poll_ctrl_test;
  localparam int AW = 18;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] poll_addr_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          busy_o, done_o, pass_o, rd_req_o, wr_req_o;
  logic [AW-1:0] bus_addr_o;
  logic [7:0]    bus_wdata_o;
  logic [7:0]    bus_rdata_i = 8'h00;
  logic          bus_valid_i = 1'b0;

  tbp_poll_ctrl #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_addr_i(poll_addr_i),
    .max_polls_i(max_polls_i), .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o),
    .rd_req_o(rd_req_o), .wr_req_o(wr_req_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_valid_i(bus_valid_i)
  );

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit cmp_on = 1'b0;

  logic [7:0] rq[$];
  int lat = 1;
  int bw = 0;
  int reads = 0;
  int writes = 0;
  logic [7:0]    w_data = '0;
  logic [AW-1:0] w_addr = '0;

  // Behavioural reference state
  int            m_phase = 0;
  int            m_pairs = 0;
  int            m_limit = 0;
  bit            m_ref = 1'b0;
  bit            m_done = 1'b0;
  bit            m_pass = 1'b0;
  logic [AW-1:0] m_addr = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] st(input bit b6, input bit b5);
    return {~b6, b6, b5, 5'b10101};
  endfunction

  // Bus slave: answers after lat cycles, one access per valid pulse
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_valid_i = 1'b0;
      bw = 0;
    end else if (bus_valid_i) begin
      bus_valid_i = 1'b0;
    end else if (rd_req_o || wr_req_o) begin
      bw++;
      if (bw >= lat) begin
        bw = 0;
        bus_valid_i = 1'b1;
        if (rd_req_o) begin
          bus_rdata_i = (rq.size() > 0) ? rq.pop_front() : 8'h00;
          reads++;
        end else begin
          writes++;
          w_data = bus_wdata_o;
          w_addr = bus_addr_o;
        end
      end
    end
  end

  // Reference model, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_done = 1'b0; m_pass = 1'b0; m_pairs = 0;
    end else begin
      m_done = 1'b0;
      if (m_phase == 0) begin
        if (start_i) begin
          m_phase = 1; m_pairs = 0; m_addr = poll_addr_i;
          m_limit = (max_polls_i == 0) ? 1 : int'(max_polls_i);
        end
      end else if (bus_valid_i) begin
        if (m_phase == 1 || m_phase == 3) begin
          m_ref = bus_rdata_i[6];
          m_phase = m_phase + 1;
        end else if (m_phase == 2 || m_phase == 4) begin
          if (bus_rdata_i[6] == m_ref) begin
            m_phase = 0; m_done = 1'b1; m_pass = 1'b1;
          end else if (m_phase == 4) begin
            m_phase = 5;
          end else if (bus_rdata_i[5]) begin
            m_phase = 3;
          end else begin
            m_pairs++;
            m_phase = (m_pairs >= m_limit) ? 5 : 1;
          end
        end else begin
          m_phase = 0; m_done = 1'b1; m_pass = 1'b0;
        end
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (cmp_on) begin
      chk(busy_o == (m_phase != 0), "R2 busy", busy_o, m_phase != 0);
      chk(rd_req_o == (m_phase >= 1 && m_phase <= 4), "R2 rd_req", rd_req_o, m_phase >= 1 && m_phase <= 4);
      chk(wr_req_o == (m_phase == 5), "R6 wr_req", wr_req_o, m_phase == 5);
      chk(done_o == m_done, "R8 done", done_o, m_done);
      if (m_done) chk(pass_o == m_pass, "R8 pass", pass_o, m_pass);
      if (m_phase != 0) chk(bus_addr_o == m_addr, "R2 addr", bus_addr_o, m_addr);
    end
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic pulse_start(input logic [AW-1:0] a, input int lim);
    poll_addr_i = a;
    max_polls_i = CW'(lim);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input logic [AW-1:0] a, input int lim, input int l,
                     input int exp_reads, input int exp_writes, input bit exp_pass,
                     input string tag);
    lat = l;
    reads = 0; writes = 0;
    @(negedge clk);
    pulse_start(a, lim);
    wait_done();
    chk(done_o == 1'b1, {tag, " done seen"}, done_o, 1);
    chk(pass_o == exp_pass, {tag, " result"}, pass_o, exp_pass);
    chk(reads == exp_reads, {tag, " read count"}, reads, exp_reads);
    chk(writes == exp_writes, {tag, " write count"}, writes, exp_writes);
    if (exp_writes > 0) begin
      chk(w_data == 8'hF0, {tag, " reset data"}, w_data, 8'hF0);
      chk(w_addr == a, {tag, " reset addr"}, w_addr, a);
    end
    rq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !rd_req_o && !wr_req_o, "R1 reset outputs",
        {busy_o, done_o, rd_req_o, wr_req_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1'b1;
    chk(!busy_o && !rd_req_o, "R1 idle after release", {busy_o, rd_req_o}, 0);

    // R3: stable bit 6 on the first pair
    rq.push_back(st(0, 0)); rq.push_back(st(0, 0));
    run(18'h00555, 4, 1, 2, 0, 1'b1, "R3");

    // R4: toggle with bit 5 low, new pair uses its own reference
    rq.push_back(st(0, 0)); rq.push_back(st(1, 0));
    rq.push_back(st(0, 0)); rq.push_back(st(0, 0));
    run(18'h02AAA, 4, 2, 4, 0, 1'b1, "R4");

    // R5: toggle with bit 5 high, confirmation pair stable
    rq.push_back(st(0, 0)); rq.push_back(st(1, 1));
    rq.push_back(st(1, 1)); rq.push_back(st(1, 1));
    run(18'h10000, 4, 1, 4, 0, 1'b1, "R5");

    // R6: confirmation pair still toggling -> reset write, fail
    rq.push_back(st(0, 0)); rq.push_back(st(1, 1));
    rq.push_back(st(0, 1)); rq.push_back(st(1, 1));
    run(18'h3FFFF, 4, 2, 4, 1, 1'b0, "R6");

    // R7: budget of 3 toggling pairs exhausted
    for (int i = 0; i < 8; i++) rq.push_back(st(i[0], 0));
    run(18'h01234, 3, 1, 6, 1, 1'b0, "R7 budget3");

    // R7: budget 0 behaves as 1
    for (int i = 0; i < 4; i++) rq.push_back(st(i[0], 0));
    run(18'h04321, 0, 1, 2, 1, 1'b0, "R7 budget0");

    // R10: stop and timeout on the same read -> pass, no confirmation
    rq.push_back(st(1, 0)); rq.push_back(st(1, 1));
    run(18'h00ABC, 4, 1, 2, 0, 1'b1, "R10");

    // R9: start while busy is ignored (new addr/budget would change the result)
    rq.push_back(st(0, 0)); rq.push_back(st(1, 0));
    rq.push_back(st(1, 0)); rq.push_back(st(1, 0));
    lat = 3; reads = 0; writes = 0;
    @(negedge clk);
    pulse_start(18'h05050, 5);
    repeat (2) @(negedge clk);
    pulse_start(18'h0A0A0, 0);
    wait_done();
    chk(pass_o == 1'b1, "R9 result unchanged", pass_o, 1);
    chk(reads == 4, "R9 read count", reads, 4);
    chk(writes == 0, "R9 no reset write", writes, 0);
    rq.delete();

    // R8: start in the done cycle is accepted immediately
    rq.push_back(st(1, 0)); rq.push_back(st(1, 0));
    rq.push_back(st(0, 0)); rq.push_back(st(1, 1));
    rq.push_back(st(1, 1)); rq.push_back(st(0, 1));
    lat = 1; reads = 0; writes = 0;
    @(negedge clk);
    pulse_start(18'h00111, 2);
    wait_done();
    chk(pass_o == 1'b1, "R8 first op pass", pass_o, 1);
    reads = 0;
    pulse_start(18'h00222, 2);
    chk(busy_o == 1'b1, "R8 chained start accepted", busy_o, 1);
    wait_done();
    chk(pass_o == 1'b0, "R8 second op fail", pass_o, 0);
    chk(reads == 4 && writes == 1, "R8 second op accesses", reads * 16 + writes, 4 * 16 + 1);
    chk(w_addr == 18'h00222, "R8 second op reset addr", w_addr, 18'h00222);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
    rq.delete();

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule